// File: doc/BRIEF.md
# Power-Down Mode Control Register

This block is a single 32-bit control register. It sets when a chip enters its low-power state, which oscillators run, and how the crystal oscillators are configured. Software reaches it through a plain write bus with an address, a write enable, data and four byte strobes. The bus accepts every write in the cycle it is presented, so there is no back-pressure. The read port returns the register contents combinationally. The crystal mode selects, the gain codes and the power-down enable are protected fields. A write changes them only while the unlock input is high. The other fields always accept writes.

Setting the power-down enable only arms the block. The low-power state starts when the processor also signals sleep. While the chip is powered down, the enables for the fast crystal and the fast RC oscillator are held low. The slow oscillators keep following their register bits. A wake-up event ends power-down within one clock, clears the enable, and latches a wake flag that can raise an interrupt. An optional wake delay holds a clock-ready indication low for a fixed number of cycles after the fast oscillators restart.

Top module: `pwrdn_ctl_reg`

## Requirements
- R1: A write lands only when `bus_we` is high and `bus_addr` equals `REG_ADDR`; `bus_rdata` always shows the register; bits 23:8 read as zero and ignore writes.
- R2: After reset the register reads 0xB900_0010: bit 31 fast crystal mode = 1, bits 30:28 fast gain = 3'b011, bit 27 slow crystal mode = 1, bits 26:24 slow gain = 3'b001, bit 4 wake delay enable = 1, and all other bits 0.
- R3: Bits 31:24 (fast mode, fast gain, slow mode, slow gain) are written from lane 3 (`bus_be[3]`) only while `unlocked` is 1; while locked the write to them is dropped.
- R4: Bit 7 (power-down enable) is written from lane 0 only while unlocked; bits 5:0 in the same write update regardless of the lock.
- R5: `pd_req` rises only when bit 7 and `cpu_sleep` are both 1 at a clock edge; bit 7 alone leaves the block armed and `pd_req` low.
- R6: A wake-up during power-down clears bit 7 in hardware, so a `cpu_sleep` that stays high does not start a second power-down.
- R7: While `pd_req` is 1, `fast_xtal_en` and `fast_rc_en` are 0; otherwise they equal bits 0 and 2.
- R8: `slow_xtal_en` and `slow_rc_en` always equal bits 1 and 3, whatever the power-down state.
- R9: Bit 6 (wake flag) is set by a `wake_evt` seen during power-down and by nothing else; writing 1 to it in lane 0 clears it, and writing 0 leaves it alone.
- R10: `wake_irq` is 1 exactly while bit 6 and bit 5 (wake interrupt enable) are both 1.
- R11: `pd_req` falls on the clock edge that samples `wake_evt`; an armed block whose bit 7 is cleared returns to active and does not power down.
- R12: `clk_ready` is 0 during power-down. After a wake with bit 4 = 1 it stays 0 for `READY_DLY` cycles. After a wake with bit 4 = 0 it is 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Write address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, bit i enables bits 8i+7:8i |
| bus_rdata | output | 32 | Register contents |
| unlocked | input | 1 | 1 allows writes to protected fields |
| cpu_sleep | input | 1 | Processor sleep indication |
| wake_evt | input | 1 | Wake-up event |
| pd_req | output | 1 | Power-down in progress |
| fast_xtal_en | output | 1 | Fast crystal oscillator enable |
| fast_rc_en | output | 1 | Fast RC oscillator enable |
| slow_xtal_en | output | 1 | Slow crystal oscillator enable |
| slow_rc_en | output | 1 | Slow RC oscillator enable |
| fast_xtal_mode | output | 1 | Fast crystal mode select (1 crystal, 0 external clock) |
| fast_xtal_gain | output | 3 | Fast crystal gain code |
| slow_xtal_mode | output | 1 | Slow crystal mode select |
| slow_xtal_gain | output | 3 | Slow crystal gain code |
| wake_irq | output | 1 | Wake-up interrupt |
| clk_ready | output | 1 | Fast clocks settled |

## Verification
Some rules are checked by assertions on every cycle. These are: the protected high byte holds while locked, power-down cannot start without both the enable and sleep, a wake ends power-down within one clock and clears the enable while setting the flag, and a delayed wake holds clock-ready low. Other behaviour can only be shown by the bench's scenarios. This covers the byte-strobe and address decoding and the reserved bits reading zero. It also covers the silent drop of a locked enable write while the gain and enable bits of the same write still land, the write-one-to-clear flag, interrupt masking, the exact length of the ready delay, and an armed block being cancelled.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  // Stored fields; [15:8] map to register bits 31:24, [7:0] to bits 7:0.
  typedef struct packed {
    logic       fx_mode;
    logic [2:0] fx_gain;
    logic       sx_mode;
    logic [2:0] sx_gain;
    logic       pd_en;
    logic       wk_flag;
    logic       wk_ie;
    logic       wk_dly;
    logic       srcl_en;
    logic       frc_en;
    logic       sx_en;
    logic       fx_en;
  } pdc_fields_t;

  localparam int          STORE_W    = 16;
  localparam int          REG_W      = 32;
  localparam int          BIT_PDEN   = 7;
  localparam int          BIT_FLAG   = 6;
  localparam int          FREE_MSB   = 5;
  localparam logic [15:0] PDC_RESET  = 16'hB910;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ARMED  = 2'd1,
    ST_PD     = 2'd2
  } pd_state_t;

endpackage

// File: rtl/pwrdn_regfile.sv
module pwrdn_regfile
  import pwrdn_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [7:0]  wd_hi,
  input  logic [7:0]  wd_lo,
  input  logic        unlocked,
  input  logic        wake_hit,
  output pdc_fields_t fields
);

  logic [STORE_W-1:0] cur_q, nxt_v;

  always_comb begin
    nxt_v = cur_q;
    // lane 3: all protected
    if (wr_hi && unlocked)
      nxt_v[15:8] = wd_hi;
    if (wr_lo) begin
      nxt_v[FREE_MSB:0] = wd_lo[FREE_MSB:0];
      if (unlocked)
        nxt_v[BIT_PDEN] = wd_lo[BIT_PDEN];
      if (wd_lo[BIT_FLAG])
        nxt_v[BIT_FLAG] = 1'b0;
    end
    // hardware wake update wins over a same-cycle write
    if (wake_hit) begin
      nxt_v[BIT_PDEN] = 1'b0;
      nxt_v[BIT_FLAG] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= PDC_RESET;
    else        cur_q <= nxt_v;
  end

  assign fields = pdc_fields_t'(cur_q);

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(cur_q[15:8]));

  assert_wake_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> (!fields.pd_en && fields.wk_flag));

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_en,
  input  logic cpu_sleep,
  input  logic wake_evt,
  output logic pd_active,
  output logic wake_hit
);

  pd_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ACTIVE: begin
        if (pd_en && cpu_sleep) st_d = ST_PD;
        else if (pd_en)         st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!pd_en)         st_d = ST_ACTIVE;
        else if (cpu_sleep) st_d = ST_PD;
      end
      ST_PD: begin
        if (wake_evt) st_d = ST_ACTIVE;
      end
      default: st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ACTIVE;
    else        st_q <= st_d;
  end

  assign pd_active = (st_q == ST_PD);
  assign wake_hit  = pd_active && wake_evt;

  assert_entry_needs_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_active && !(pd_en && cpu_sleep)) |=> !pd_active);

  assert_wake_one_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && wake_evt) |=> !pd_active);

endmodule

// File: rtl/pwrdn_osc_gate.sv
module pwrdn_osc_gate #(
  parameter int READY_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_active,
  input  logic wake_hit,
  input  logic wk_dly,
  input  logic fx_bit,
  input  logic frc_bit,
  input  logic sx_bit,
  input  logic srcl_bit,
  output logic fast_xtal_en,
  output logic fast_rc_en,
  output logic slow_xtal_en,
  output logic slow_rc_en,
  output logic clk_ready
);

  assign fast_xtal_en = fx_bit  && !pd_active;
  assign fast_rc_en   = frc_bit && !pd_active;
  assign slow_xtal_en = sx_bit;
  assign slow_rc_en   = srcl_bit;

  generate
    if (READY_DLY == 0) begin : g_nodly
      assign clk_ready = !pd_active;
    end else begin : g_dly
      localparam int CNT_W = $clog2(READY_DLY + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (wake_hit)
          cnt_q <= wk_dly ? CNT_W'(READY_DLY) : '0;
        else if (cnt_q != '0)
          cnt_q <= cnt_q - 1'b1;
      end

      assign clk_ready = !pd_active && (cnt_q == '0);

      assert_ready_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_hit && wk_dly) |=> !clk_ready);
    end
  endgenerate

endmodule

// File: rtl/pwrdn_ctl_reg.sv
module pwrdn_ctl_reg
  import pwrdn_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int              READY_DLY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  input  logic              unlocked,
  input  logic              cpu_sleep,
  input  logic              wake_evt,
  output logic              pd_req,
  output logic              fast_xtal_en,
  output logic              fast_rc_en,
  output logic              slow_xtal_en,
  output logic              slow_rc_en,
  output logic              fast_xtal_mode,
  output logic [2:0]        fast_xtal_gain,
  output logic              slow_xtal_mode,
  output logic [2:0]        slow_xtal_gain,
  output logic              wake_irq,
  output logic              clk_ready
);

  localparam int RSV_W = REG_W - STORE_W;

  pdc_fields_t fields;
  logic        hit, wake_hit, pd_active;

  assign hit = bus_we && (bus_addr == REG_ADDR);

  pwrdn_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hi    (hit && bus_be[3]),
    .wr_lo    (hit && bus_be[0]),
    .wd_hi    (bus_wdata[31:24]),
    .wd_lo    (bus_wdata[7:0]),
    .unlocked (unlocked),
    .wake_hit (wake_hit),
    .fields   (fields)
  );

  pwrdn_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_en     (fields.pd_en),
    .cpu_sleep (cpu_sleep),
    .wake_evt  (wake_evt),
    .pd_active (pd_active),
    .wake_hit  (wake_hit)
  );

  pwrdn_osc_gate #(.READY_DLY(READY_DLY)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_active    (pd_active),
    .wake_hit     (wake_hit),
    .wk_dly       (fields.wk_dly),
    .fx_bit       (fields.fx_en),
    .frc_bit      (fields.frc_en),
    .sx_bit       (fields.sx_en),
    .srcl_bit     (fields.srcl_en),
    .fast_xtal_en (fast_xtal_en),
    .fast_rc_en   (fast_rc_en),
    .slow_xtal_en (slow_xtal_en),
    .slow_rc_en   (slow_rc_en),
    .clk_ready    (clk_ready)
  );

  assign bus_rdata      = {fields[15:8], {RSV_W{1'b0}}, fields[7:0]};
  assign pd_req         = pd_active;
  assign fast_xtal_mode = fields.fx_mode;
  assign fast_xtal_gain = fields.fx_gain;
  assign slow_xtal_mode = fields.sx_mode;
  assign slow_xtal_gain = fields.sx_gain;
  assign wake_irq       = fields.wk_flag && fields.wk_ie;

endmodule

// File: tb/pwrdn_ctl_reg_bench.sv
module pwrdn_ctl_reg_bench;

  localparam int DLY = 6;

  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        unlocked = 0, cpu_sleep = 0, wake_evt = 0;
  logic        pd_req, fast_xtal_en, fast_rc_en, slow_xtal_en, slow_rc_en;
  logic        fast_xtal_mode, slow_xtal_mode, wake_irq, clk_ready;
  logic [2:0]  fast_xtal_gain, slow_xtal_gain;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pwrdn_ctl_reg #(.ADDR_W(12), .REG_ADDR(12'h000), .READY_DLY(DLY)) u_pwrdn_ctl_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .unlocked(unlocked), .cpu_sleep(cpu_sleep), .wake_evt(wake_evt),
    .pd_req(pd_req), .fast_xtal_en(fast_xtal_en), .fast_rc_en(fast_rc_en),
    .slow_xtal_en(slow_xtal_en), .slow_rc_en(slow_rc_en),
    .fast_xtal_mode(fast_xtal_mode), .fast_xtal_gain(fast_xtal_gain),
    .slow_xtal_mode(slow_xtal_mode), .slow_xtal_gain(slow_xtal_gain),
    .wake_irq(wake_irq), .clk_ready(clk_ready)
  );

  // {unlocked, be, wdata, expected readback}; state carries from row to row (R1 R3 R4)
  localparam logic [68:0] VEC [0:5] = '{
    {1'b1, 4'hF, 32'h4200_0023, 32'h4200_0023},
    {1'b0, 4'hF, 32'hFFFF_FF1C, 32'h4200_001C},
    {1'b1, 4'h1, 32'hFF00_000F, 32'h4200_000F},
    {1'b1, 4'h8, 32'h9100_00FF, 32'h9100_000F},
    {1'b1, 4'h6, 32'hFFFF_FFFF, 32'h9100_000F},
    {1'b0, 4'h9, 32'h0000_0030, 32'h9100_0030}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] b, input logic unl,
                    input logic [11:0] a = 12'h000);
    @(negedge clk);
    bus_we = 1; bus_wdata = d; bus_be = b; unlocked = unl; bus_addr = a;
    @(negedge clk);
    bus_we = 0; bus_be = '0;
  endtask

  task automatic wake_pulse();
    @(negedge clk);
    wake_evt = 1;
    @(negedge clk);
    wake_evt = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset value", bus_rdata, 32'hB900_0010);
    chk("R2 modes/gains", {24'h0, fast_xtal_mode, fast_xtal_gain, slow_xtal_mode, slow_xtal_gain},
        {24'h0, 1'b1, 3'b011, 1'b1, 3'b001});
    chk("R2 idle outputs", {27'h0, pd_req, wake_irq, fast_xtal_en, slow_rc_en, clk_ready},
        {27'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][63:32], VEC[i][67:64], VEC[i][68]);
      chk($sformatf("R1/R3/R4 vector %0d", i), bus_rdata, VEC[i][31:0]);
    end
    chk("R3 gain out", {29'h0, fast_xtal_gain}, 32'h1);

    // R1 other address ignored
    wr(32'h0000_000F, 4'hF, 1'b1, 12'h004);
    chk("R1 wrong address", bus_rdata, 32'h9100_0030);

    // R4 locked enable dropped, free bits land
    wr(32'h0000_00BF, 4'h1, 1'b0);
    chk("R4 locked pd_en", bus_rdata, 32'h9100_003F);
    cpu_sleep = 1;
    repeat (3) @(negedge clk);
    chk("R5 no enable no pd", {31'h0, pd_req}, 32'h0);
    chk("R7 fast on when active", {31'h0, fast_xtal_en}, 32'h1);
    cpu_sleep = 0;

    // R5 armed waits for sleep
    wr(32'h0000_00BF, 4'h1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R5 armed no sleep", {31'h0, pd_req}, 32'h0);
    cpu_sleep = 1;
    @(negedge clk);
    chk("R5 enter pd", {31'h0, pd_req}, 32'h1);
    chk("R7 fast forced off", {30'h0, fast_xtal_en, fast_rc_en}, 32'h0);
    chk("R8 slow kept", {30'h0, slow_xtal_en, slow_rc_en}, 32'h3);
    chk("R12 not ready in pd", {31'h0, clk_ready}, 32'h0);
    wr(32'h0000_00B3, 4'h1, 1'b1);
    chk("R8 slow follows bit in pd", {30'h0, slow_xtal_en, slow_rc_en}, 32'h2);
    wr(32'h0000_00BF, 4'h1, 1'b1);
    chk("R11 still in pd", {31'h0, pd_req}, 32'h1);

    // wake with delay
    wake_pulse();
    chk("R11 wake one clock", {31'h0, pd_req}, 32'h0);
    chk("R7 fast restored", {30'h0, fast_xtal_en, fast_rc_en}, 32'h3);
    chk("R6/R9 autoclear and flag", bus_rdata, 32'h9100_007F);
    chk("R10 irq raised", {31'h0, wake_irq}, 32'h1);
    chk("R12 ready held", {31'h0, clk_ready}, 32'h0);
    repeat (DLY - 1) @(negedge clk);
    chk("R12 ready held last cycle", {31'h0, clk_ready}, 32'h0);
    @(negedge clk);
    chk("R12 ready after delay", {31'h0, clk_ready}, 32'h1);
    chk("R6 no re-entry with sleep", {31'h0, pd_req}, 32'h0);

    // R10 mask, R9 write 0 keeps and W1C clears
    wr(32'h0000_001F, 4'h1, 1'b1);
    chk("R9 write0 keeps flag", bus_rdata, 32'h9100_005F);
    chk("R10 irq masked", {31'h0, wake_irq}, 32'h0);
    wr(32'h0000_005F, 4'h1, 1'b1);
    chk("R9 w1c", bus_rdata, 32'h9100_001F);

    // R9 wake outside pd ignored
    wake_pulse();
    chk("R9 wake outside pd", bus_rdata, 32'h9100_001F);

    // R12 wake without delay (sleep still high: direct entry)
    wr(32'h0000_00AF, 4'h1, 1'b1);
    @(negedge clk);
    chk("R5 direct entry", {31'h0, pd_req}, 32'h1);
    wake_pulse();
    chk("R12 ready at once", {31'h0, clk_ready}, 32'h1);
    chk("R10 irq after wake", {31'h0, wake_irq}, 32'h1);

    // R11 armed then cancelled
    cpu_sleep = 0;
    wr(32'h0000_008F, 4'h1, 1'b1);
    wr(32'h0000_000F, 4'h1, 1'b1);
    cpu_sleep = 1;
    repeat (2) @(negedge clk);
    chk("R11 armed cancel", {31'h0, pd_req}, 32'h0);

    // R2 reset again
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 re-reset", bus_rdata, 32'hB900_0010);

    finish_run();
  end

endmodule